// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Generator with Address Demultiplexer

This block runs the processor side of a bus whose low address byte and data byte share one set of pins. A request carries a direction, a 16-bit address and write data. The block plays it out as a fixed four-state bus cycle. In the first state, the low address byte is driven onto the shared lines and the address strobe `ale` is pulsed. The high address byte leaves on a dedicated output that is never shared. In the following states the shared lines carry data. The block drives them for a write and releases them for a read.

A matching demultiplexer is built into the same top. It watches the shared lines as they appear outside the chip. While `ale` is high its low byte follows those lines. Once `ale` falls it holds the last value. Together with the dedicated high byte, it presents a steady full address for the rest of the cycle. The shared pins are modelled as a separate output value, output enable and input value, so the block can sit behind any pad ring.

Top module: `mxbus_top`

## Requirements
- R1: After reset, `ale` is 0, `rd_n` and `wr_n` are 1, `ad_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) puts the cycle in T1 for exactly the next clock. In T1, `ale` is 1, `ad_oe` is 1 and `ad_o` equals address bits [7:0].
- R3: From T1 through T4, `a_hi` equals address bits [15:8]. The high byte never appears on `ad_o` in T1.
- R4: The strobes are active low and are asserted only in T2 and T3. A read asserts `rd_n` (0) and a write asserts `wr_n` (0). The two are never 0 together, and neither is 0 while `ale` is 1.
- R5: On a read, `ad_oe` is 0 in T2, T3 and T4. In T4, `rsp_valid` is 1 and `rsp_rdata` carries the `ad_i` value sampled at the clock edge that ends T3.
- R6: On a write, `ad_oe` is 1 and `ad_o` equals the write data in T2, T3 and T4. `rsp_valid` stays 0.
- R7: The low byte of `lat_addr` follows the shared lines while `ale` is 1. After `ale` falls it holds that value until the next `ale`. The high byte of `lat_addr` is `a_hi`.
- R8: `req_ready` is 1 only in idle and in T4. A request accepted in T4 starts its T1 in the very next clock, with no idle state between.
- R9: Values on `ad_i` outside the sampling edge at the end of T3 have no effect on `rsp_rdata`. This holds during T1, T2 and T4 and after the cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Full cycle address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid (T4 of a read) |
| rsp_rdata | output | 8 | Read data captured at end of T3 |
| ad_o | output | 8 | Shared lines, value driven out |
| ad_oe | output | 1 | Shared lines, drive enable |
| ad_i | input | 8 | Shared lines, value seen from outside |
| a_hi | output | 8 | Dedicated high address byte |
| ale | output | 1 | Address strobe, high in T1 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| lat_addr | output | 16 | Demultiplexed full address |

## Verification
A wrong state in the sequencer shows within one clock as a misplaced `ale` pulse, a strobe in the wrong state, or `ad_oe` on during a read. A wrong latch value shows on `lat_addr` in the state right after `ale` falls. A read data register that samples on the wrong edge shows in T4 as a `rsp_rdata` value taken from T2 or T4 instead of T3. The bench steps through every state of many cycles with mixed directions and addresses. It compares the pins in each state against values computed from the request.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_T3   = 3'd3,
      ST_T4   = 3'd4
   } mx_state_e;
endpackage

// File: rtl/mxbus_seq.sv
module mxbus_seq
   import mxbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] ad_i,
   output logic              req_ready,
   output mx_state_e         state,
   output logic              cur_write,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [DATA_W-1:0] cur_wdata,
   output logic [DATA_W-1:0] rd_data
);
   mx_state_e nxt;
   logic      accept;

   assign req_ready = (state == ST_IDLE) || (state == ST_T4);
   assign accept    = req_valid && req_ready;

   always_comb begin
      unique case (state)
         ST_IDLE: nxt = accept ? ST_T1 : ST_IDLE;
         ST_T1:   nxt = ST_T2;
         ST_T2:   nxt = ST_T3;
         ST_T3:   nxt = ST_T4;
         ST_T4:   nxt = accept ? ST_T1 : ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cur_write <= 1'b0;
         cur_addr  <= '0;
         cur_wdata <= '0;
         rd_data   <= '0;
      end else begin
         state <= nxt;
         if (accept) begin
            cur_write <= req_write;
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
         end
         if (state == ST_T3 && !cur_write) rd_data <= ad_i;
      end
   end
endmodule

// File: rtl/mxbus_pins.sv
module mxbus_pins
   import mxbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  mx_state_e         state,
   input  logic              cur_write,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [DATA_W-1:0] cur_wdata,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic              ad_oe,
   output logic [DATA_W-1:0] ad_o,
   output logic [ADDR_W-DATA_W-1:0] a_hi,
   output logic              rsp_valid
);
   logic in_t1, strobe_win, data_win;

   assign in_t1      = (state == ST_T1);
   assign strobe_win = (state == ST_T2) || (state == ST_T3);
   assign data_win   = strobe_win || (state == ST_T4);

   assign ale       = in_t1;
   assign rd_n      = !(strobe_win && !cur_write);
   assign wr_n      = !(strobe_win && cur_write);
   assign ad_oe     = in_t1 || (data_win && cur_write);
   assign ad_o      = in_t1 ? cur_addr[DATA_W-1:0] : cur_wdata;
   assign a_hi      = cur_addr[ADDR_W-1:DATA_W];
   assign rsp_valid = (state == ST_T4) && !cur_write;
endmodule

// File: rtl/mxbus_demux.sv
module mxbus_demux #(
   parameter int  DATA_W      = 8,
   parameter int  HI_W        = 8,
   parameter bit  TRANSPARENT = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ale,
   input  logic [DATA_W-1:0]      bus,
   input  logic [HI_W-1:0]        a_hi,
   output logic [HI_W+DATA_W-1:0] lat_addr
);
   logic [DATA_W-1:0] held;
   logic [DATA_W-1:0] lo;

   always_ff @(posedge clk) begin
      if (!rst_n)   held <= '0;
      else if (ale) held <= bus;
   end

   generate
      if (TRANSPARENT) begin : g_follow
         assign lo = ale ? bus : held;
      end else begin : g_capture
         assign lo = held;
      end
   endgenerate

   assign lat_addr = {a_hi, lo};
endmodule

// File: rtl/mxbus_top.sv
module mxbus_top
   import mxbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter bit LATCH_TRANSPARENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [DATA_W-1:0] ad_o,
   output logic              ad_oe,
   input  logic [DATA_W-1:0] ad_i,
   output logic [ADDR_W-DATA_W-1:0] a_hi,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic [ADDR_W-1:0] lat_addr
);
   localparam int HI_W = ADDR_W - DATA_W;

   generate
      if (HI_W < 1) begin : g_bad_width
         $error("mxbus_top: ADDR_W must exceed DATA_W");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("mxbus_top: DATA_W must be positive");
      end
   endgenerate

   mx_state_e         state;
   logic              cur_write;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] cur_wdata;
   logic [DATA_W-1:0] pad_view;

   mxbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .ad_i(ad_i), .req_ready(req_ready), .state(state),
      .cur_write(cur_write), .cur_addr(cur_addr),
      .cur_wdata(cur_wdata), .rd_data(rsp_rdata)
   );

   mxbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
      .state(state), .cur_write(cur_write), .cur_addr(cur_addr),
      .cur_wdata(cur_wdata), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
      .ad_oe(ad_oe), .ad_o(ad_o), .a_hi(a_hi), .rsp_valid(rsp_valid)
   );

   // value present on the shared lines as an external device sees them
   assign pad_view = ad_oe ? ad_o : ad_i;

   mxbus_demux #(.DATA_W(DATA_W), .HI_W(HI_W),
                 .TRANSPARENT(LATCH_TRANSPARENT)) u_demux (
      .clk(clk), .rst_n(rst_n), .ale(ale), .bus(pad_view),
      .a_hi(a_hi), .lat_addr(lat_addr)
   );
endmodule

// File: rtl/mxbus_chk.sv
module mxbus_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              ad_oe,
   input logic              ale,
   input logic              rd_n,
   input logic              wr_n,
   input logic [ADDR_W-DATA_W-1:0] a_hi,
   input logic [ADDR_W-1:0] lat_addr
);
   assert_ale_no_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (rd_n && wr_n));
   assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> wr_n);
   assert_ale_one_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);
   assert_read_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_oe);
   assert_rsp_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (!ad_oe && rd_n && wr_n));
   assert_write_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> ad_oe);
   assert_latch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ale |-> $stable(lat_addr[DATA_W-1:0]));
   assert_hi_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ale && !req_ready) |-> $stable(a_hi));
   assert_ready_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (rd_n && wr_n && !ale));
endmodule

bind mxbus_top mxbus_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
   .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
   .a_hi(a_hi), .lat_addr(lat_addr)
);

// File: tb/tb_mxbus_top.sv
`timescale 1ns/1ps
module tb_mxbus_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rsp_valid;
   logic [7:0]  rsp_rdata;
   logic [7:0]  ad_o;
   logic        ad_oe;
   logic [7:0]  ad_i = '0;
   logic [7:0]  a_hi;
   logic        ale, rd_n, wr_n;
   logic [15:0] lat_addr;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mxbus_top dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ad_o(ad_o), .ad_oe(ad_oe),
      .ad_i(ad_i), .a_hi(a_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
      .lat_addr(lat_addr)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_eq(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
      chk(act === exp, tag, act, exp);
   endtask

   // runs one bus cycle; if started, T1 was entered from a chained accept
   task automatic bus_cycle(input bit wr, input logic [15:0] a,
                            input logic [7:0] wd, input logic [7:0] rv,
                            input bit started, input bit chain,
                            input bit nwr, input logic [15:0] na,
                            input logic [7:0] nwd);
      if (!started) begin
         chk_eq("R8 ready in idle", {31'd0, req_ready}, 32'd1);
         req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
         @(negedge clk);
      end
      req_valid = 1'b0;
      // T1
      chk_eq("R2 ale in T1", {31'd0, ale}, 32'd1);
      chk_eq("R2 oe in T1", {31'd0, ad_oe}, 32'd1);
      chk_eq("R2 low addr on ad_o", {24'd0, ad_o}, {24'd0, a[7:0]});
      chk_eq("R3 high addr in T1", {24'd0, a_hi}, {24'd0, a[15:8]});
      chk_eq("R4 no strobe in T1", {30'd0, rd_n, wr_n}, 32'd3);
      chk_eq("R7 latch follows in T1", {16'd0, lat_addr}, {16'd0, a});
      chk_eq("R8 not ready in T1", {31'd0, req_ready}, 32'd0);
      ad_i = ~rv;
      @(negedge clk);
      // T2
      chk_eq("R2 ale low in T2", {31'd0, ale}, 32'd0);
      chk_eq("R4 strobes in T2", {30'd0, rd_n, wr_n}, wr ? 32'd2 : 32'd1);
      chk_eq("R3 high addr in T2", {24'd0, a_hi}, {24'd0, a[15:8]});
      chk_eq("R7 latch holds in T2", {16'd0, lat_addr}, {16'd0, a});
      if (wr) begin
         chk_eq("R6 oe in T2", {31'd0, ad_oe}, 32'd1);
         chk_eq("R6 wdata in T2", {24'd0, ad_o}, {24'd0, wd});
      end else begin
         chk_eq("R5 released in T2", {31'd0, ad_oe}, 32'd0);
      end
      ad_i = rv;
      @(negedge clk);
      // T3
      chk_eq("R4 strobes in T3", {30'd0, rd_n, wr_n}, wr ? 32'd2 : 32'd1);
      chk_eq("R7 latch holds in T3", {16'd0, lat_addr}, {16'd0, a});
      chk_eq("R5/R6 oe in T3", {31'd0, ad_oe}, {31'd0, wr});
      @(negedge clk);
      // T4
      chk_eq("R4 strobes off in T4", {30'd0, rd_n, wr_n}, 32'd3);
      chk_eq("R8 ready in T4", {31'd0, req_ready}, 32'd1);
      chk_eq("R3 high addr in T4", {24'd0, a_hi}, {24'd0, a[15:8]});
      chk_eq("R7 latch holds in T4", {16'd0, lat_addr}, {16'd0, a});
      if (wr) begin
         chk_eq("R6 oe in T4", {31'd0, ad_oe}, 32'd1);
         chk_eq("R6 wdata in T4", {24'd0, ad_o}, {24'd0, wd});
         chk_eq("R6 no rsp on write", {31'd0, rsp_valid}, 32'd0);
      end else begin
         chk_eq("R5 released in T4", {31'd0, ad_oe}, 32'd0);
         chk_eq("R5 rsp_valid in T4", {31'd0, rsp_valid}, 32'd1);
         chk_eq("R5 rdata in T4", {24'd0, rsp_rdata}, {24'd0, rv});
      end
      ad_i = rv ^ 8'h5A;
      if (chain) begin
         req_valid = 1'b1; req_write = nwr; req_addr = na; req_wdata = nwd;
      end
      @(negedge clk);
      if (!wr)
         chk_eq("R9 rdata unaffected after T3", {24'd0, rsp_rdata}, {24'd0, rv});
      if (chain) begin
         chk_eq("R8 chained T1 follows T4", {31'd0, ale}, 32'd1);
      end else begin
         chk_eq("R1 idle after cycle", {29'd0, ale, ad_oe, rsp_valid}, 32'd0);
         chk_eq("R7 latch holds in idle", {16'd0, lat_addr}, {16'd0, a});
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk_eq("R1 ale reset", {31'd0, ale}, 32'd0);
      chk_eq("R1 strobes reset", {30'd0, rd_n, wr_n}, 32'd3);
      chk_eq("R1 oe reset", {31'd0, ad_oe}, 32'd0);
      chk_eq("R1 rsp reset", {31'd0, rsp_valid}, 32'd0);
      chk_eq("R1 ready reset", {31'd0, req_ready}, 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk_eq("R1 idle after release", {30'd0, ale, ad_oe}, 32'd0);

      for (int i = 0; i < 48; i++) begin
         logic [15:0] a;
         logic [7:0]  d, r;
         a = 16'(i * 16'h0531 + 16'h00A7) ^ 16'(i << 12);
         d = 8'(i * 29 + 3);
         r = 8'(i * 83 + 17);
         bus_cycle(i[0], a, d, r, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0);
         repeat (i % 3) @(negedge clk);
      end
      // corner addresses and chained back-to-back cycles
      bus_cycle(1'b0, 16'hFFFF, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b1, 16'h0000, 8'hA5);
      bus_cycle(1'b1, 16'h0000, 8'hA5, 8'h00, 1'b1, 1'b1, 1'b0, 16'h00FF, 8'h00);
      bus_cycle(1'b0, 16'h00FF, 8'h00, 8'h3C, 1'b1, 1'b1, 1'b0, 16'hFF00, 8'h00);
      bus_cycle(1'b0, 16'hFF00, 8'h00, 8'hC3, 1'b1, 1'b0, 1'b0, 16'h0, 8'h0);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule